// File: doc/BRIEF.md
# Packet-Boundary Strict Priority Output Scheduler

This block sits in front of a single shared serial transmit port and decides which packet goes out next. Packets arrive one byte per cycle on a single input stream, and each packet carries a two-bit priority. Every packet is written into one of four byte queues, and the queue is picked by that priority. The output side is a valid/ready byte stream that carries an end-of-packet flag and the priority of the queue being served.

Level 0 is the most urgent level. While no packet is in flight, the scheduler presents the head of the most urgent queue that holds a complete packet. Once the first byte of a packet has been accepted, the rest of that packet goes out before any other queue is looked at, even if more urgent traffic arrives in the meantime. Less urgent queues can therefore be starved under sustained load.

A packet that does not fit in its queue is discarded in full, and the drop counter for that queue goes up by one. A packet only becomes visible at the output once its last byte has been stored.

Top module: `sp_pkt_sched`

## Requirements
- R1: After reset `out_valid` is 0 and all four drop counters read 0.
- R2: A packet sent with priority p leaves on `out_prio` = p with its bytes unchanged. `out_last` is 1 on its final byte only.
- R3: Whenever no packet is in progress and `out_valid` is 1, `out_prio` is the smallest index among the queues that hold a complete packet.
- R4: The cycle after a final byte is accepted, `out_valid` is 1 if any other queue holds a complete packet. No idle cycle is inserted between back-to-back packets.
- R5: After a non-final byte is accepted, the following bytes come from the same queue until `out_last`. More urgent arrivals do not preempt the packet.
- R6: Packets of equal priority leave in arrival order.
- R7: Queue fill is counted as committed bytes plus the bytes of a packet still being written. If an input byte arrives while its queue already holds DEPTH bytes, the whole packet is dropped, including bytes already stored and the bytes that follow. That queue's drop counter (field q of `drop_cnt`, bits q*CNT_W upward) then increases by 1 and saturates at its maximum value. Other queues are unaffected.
- R8: A packet is eligible for output from the cycle after its last byte is written, and not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input byte present this cycle |
| in_data | input | DATA_W | Input byte |
| in_last | input | 1 | Input byte ends its packet |
| in_prio | input | 2 | Packet priority, sampled on its first byte (0 most urgent) |
| out_ready | input | 1 | Downstream takes the output byte this cycle |
| out_valid | output | 1 | Output byte present |
| out_data | output | DATA_W | Output byte |
| out_last | output | 1 | Output byte ends its packet |
| out_prio | output | 2 | Index of the queue being served |
| drop_cnt | output | 4*CNT_W | Four saturating drop counters, queue q at bits q*CNT_W upward |

## Verification
A packet whose last byte is written at a clock edge is visible at the output from the next cycle. A drop updates its counter at the edge where the overflowing byte is taken. After a final byte is accepted, the next selection is already on the outputs one cycle later. The bench drives inputs on the falling edge and samples outputs on the next falling edge. Its reference queues apply each edge's write and read in the same order as the hardware, so every expected value is compared exactly one cycle after the stimulus that causes it. The fill used for drop decisions is taken before that edge's read.

// File: rtl/sp_pkt_sched.sv
module sp_pkt_sched #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 16,
  parameter int CNT_W  = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  input  logic [DATA_W-1:0]   in_data,
  input  logic                in_last,
  input  logic [1:0]          in_prio,
  input  logic                out_ready,
  output logic                out_valid,
  output logic [DATA_W-1:0]   out_data,
  output logic                out_last,
  output logic [1:0]          out_prio,
  output logic [4*CNT_W-1:0]  drop_cnt
);
  localparam int NQ = 4;
  localparam int AW = $clog2(DEPTH);
  localparam logic [AW:0] FULL_N = AW'(0) | (AW+1)'(DEPTH);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [AW:0]     wr_ptr [NQ];
  logic [AW:0]     cm_ptr [NQ];
  logic [AW:0]     rd_ptr [NQ];
  logic [DATA_W:0] head   [NQ];
  logic [NQ-1:0]   avail, full;

  logic       in_pkt, dropping, mid;
  logic [1:0] cur_q, lock_q, pick, sel;

  wire [1:0] wq       = in_pkt ? cur_q : in_prio;
  wire       overflow = in_valid && !dropping && full[wq];
  wire       wr_en    = in_valid && !dropping && !full[wq];
  wire       rd_fire  = out_valid && out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      in_pkt   <= 1'b0;
      dropping <= 1'b0;
      cur_q    <= '0;
    end else if (in_valid) begin
      in_pkt   <= !in_last;
      dropping <= in_last ? 1'b0 : (dropping || overflow);
      if (!in_pkt) cur_q <= in_prio;
    end
  end

  for (genvar q = 0; q < NQ; q++) begin : g_q
    logic [DATA_W:0]  mem [DEPTH];
    logic [CNT_W-1:0] cnt;

    assign avail[q] = cm_ptr[q] != rd_ptr[q];
    assign full[q]  = (wr_ptr[q] - rd_ptr[q]) == FULL_N;
    assign head[q]  = mem[rd_ptr[q][AW-1:0]];
    assign drop_cnt[q*CNT_W +: CNT_W] = cnt;

    always_ff @(posedge clk)
      if (wr_en && wq == q) mem[wr_ptr[q][AW-1:0]] <= {in_last, in_data};

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        wr_ptr[q] <= '0;
        cm_ptr[q] <= '0;
        rd_ptr[q] <= '0;
        cnt       <= '0;
      end else begin
        if (wr_en && wq == q) begin
          wr_ptr[q] <= wr_ptr[q] + 1'b1;
          if (in_last) cm_ptr[q] <= wr_ptr[q] + 1'b1;
        end
        if (overflow && wq == q) begin
          wr_ptr[q] <= cm_ptr[q];
          if (cnt != CNT_MAX) cnt <= cnt + 1'b1;
        end
        if (rd_fire && sel == q) rd_ptr[q] <= rd_ptr[q] + 1'b1;
      end
    end
  end

  always_comb begin
    pick = '0;
    for (int q = NQ-1; q >= 0; q--)
      if (avail[q]) pick = 2'(q);
  end

  assign sel       = mid ? lock_q : pick;
  assign out_valid = avail[sel];
  assign out_data  = head[sel][DATA_W-1:0];
  assign out_last  = head[sel][DATA_W];
  assign out_prio  = sel;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mid    <= 1'b0;
      lock_q <= '0;
    end else if (rd_fire) begin
      mid    <= !out_last;
      lock_q <= sel;
    end
  end
endmodule

// File: rtl/sp_pkt_sched_chk.sv
module sp_pkt_sched_chk #(
  parameter int CNT_W = 8
) (
  input logic               clk,
  input logic               rst_n,
  input logic               out_valid,
  input logic               out_ready,
  input logic               out_last,
  input logic [1:0]         out_prio,
  input logic [3:0]         avail,
  input logic               mid,
  input logic [4*CNT_W-1:0] drop_cnt
);
  logic [3:0] below;
  assign below = (4'b1 << out_prio) - 4'b1;

  AST_NO_PREEMPT: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready && !out_last |=> out_valid && out_prio == $past(out_prio)); // R5

  AST_PICK_HIGHEST: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !mid |-> (avail & below) == 4'b0); // R3

  AST_NO_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready && out_last && ((avail & ~(4'b1 << out_prio)) != 4'b0) |=> out_valid); // R4

  for (genvar q = 0; q < 4; q++) begin : g_c
    AST_DROP_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      drop_cnt[q*CNT_W +: CNT_W] == $past(drop_cnt[q*CNT_W +: CNT_W]) ||
      drop_cnt[q*CNT_W +: CNT_W] == $past(drop_cnt[q*CNT_W +: CNT_W]) + 1'b1); // R7
  end

  AST_ONE_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({drop_cnt[0*CNT_W +: CNT_W] != $past(drop_cnt[0*CNT_W +: CNT_W]),
                drop_cnt[1*CNT_W +: CNT_W] != $past(drop_cnt[1*CNT_W +: CNT_W]),
                drop_cnt[2*CNT_W +: CNT_W] != $past(drop_cnt[2*CNT_W +: CNT_W]),
                drop_cnt[3*CNT_W +: CNT_W] != $past(drop_cnt[3*CNT_W +: CNT_W])}) <= 1); // R7
endmodule

bind sp_pkt_sched sp_pkt_sched_chk #(.CNT_W(CNT_W)) i_chk (
  .clk(clk), .rst_n(rst_n), .out_valid(out_valid), .out_ready(out_ready),
  .out_last(out_last), .out_prio(out_prio), .avail(avail), .mid(mid),
  .drop_cnt(drop_cnt)
);

// File: tb/test_sp_pkt_sched.sv
module test_sp_pkt_sched;
  localparam int DW = 8, DEPTH = 16, CW = 8;

  logic clk = 0, rst_n = 0;
  logic in_valid = 0, in_last = 0, out_ready = 0;
  logic [DW-1:0] in_data = '0;
  logic [1:0] in_prio = '0;
  logic out_valid, out_last;
  logic [DW-1:0] out_data;
  logic [1:0] out_prio;
  logic [4*CW-1:0] drop_cnt;

  always #5 clk = ~clk;

  sp_pkt_sched #(.DATA_W(DW), .DEPTH(DEPTH), .CNT_W(CW)) i_sp_pkt_sched (.*);

  int checks = 0, errors = 0;
  bit done = 0;

  logic [8:0] mq [4][$];
  logic [8:0] pend [$];
  int  exp_cnt [4];
  bit  m_mid = 0, m_drop = 0, m_inpkt = 0, prev_last = 0;
  int  m_lock = 0, m_curq = 0;
  int  rem = 0, pprio = 0;

  function automatic int exp_sel();
    if (m_mid) return m_lock;
    for (int q = 0; q < 4; q++) if (mq[q].size() > 0) return q;
    return -1;
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step(bit iv, logic [7:0] d, bit lst, int prio, bit rdy);
    int q;
    q = exp_sel();
    for (int k = 0; k < 4; k++)
      chk(drop_cnt[k*CW +: CW] == CW'(exp_cnt[k]), "R7 drop count", drop_cnt[k*CW +: CW], exp_cnt[k]);
    chk(out_valid == (q >= 0), prev_last ? "R4 valid" : "R8 valid", out_valid, q >= 0);
    if (out_valid && q >= 0) begin
      chk(out_prio == 2'(q), m_mid ? "R5 prio" : "R3 prio", out_prio, q);
      chk(out_data == mq[q][0][7:0], "R6 data order", out_data, mq[q][0][7:0]);
      chk(out_last == mq[q][0][8], "R2 last flag", out_last, mq[q][0][8]);
    end
    in_valid = iv; in_data = d; in_last = lst; in_prio = 2'(prio); out_ready = rdy;
    if (iv) begin
      int wq;
      wq = m_inpkt ? m_curq : prio;
      if (!m_drop) begin
        if (mq[wq].size() + pend.size() >= DEPTH) begin
          m_drop = 1; pend.delete();
          if (exp_cnt[wq] < (1 << CW) - 1) exp_cnt[wq]++;
        end else pend.push_back({lst, d});
      end
      if (lst) begin
        if (!m_drop) foreach (pend[i]) mq[wq].push_back(pend[i]);
        pend.delete(); m_drop = 0; m_inpkt = 0;
      end else begin
        m_inpkt = 1; m_curq = wq;
      end
    end
    prev_last = 0;
    if (q >= 0 && rdy) begin
      logic [8:0] b;
      b = mq[q].pop_front();
      m_mid = !b[8]; m_lock = q; prev_last = b[8];
    end
    @(negedge clk);
  endtask

  task automatic phase(int n, int p_in, int p_rdy, int maxlen, int fprio);
    for (int i = 0; i < n; i++) begin
      bit iv;
      iv = ($urandom % 100) < p_in;
      if (iv && rem == 0) begin
        rem = 1 + $urandom % maxlen;
        pprio = (fprio >= 0) ? fprio : int'($urandom % 4);
      end
      if (iv) rem--;
      step(iv, 8'($urandom), iv && rem == 0, pprio, ($urandom % 100) < p_rdy);
    end
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(out_valid == 0, "R1 reset valid", out_valid, 0);
    chk(drop_cnt == '0, "R1 reset counters", drop_cnt, 0);
    // R7 fill queue 3 with one-byte packets, then saturate its counter
    for (int i = 0; i < DEPTH + 270; i++) step(1, 8'(i), 1, 3, 0);
    // R7 multi-byte drop into full queue 3, queue 0 still accepted
    for (int i = 0; i < 3; i++) step(1, 8'hA0 + 8'(i), i == 2, 3, 0);
    for (int i = 0; i < 3; i++) step(1, 8'hB0 + 8'(i), i == 2, 0, 0);
    step(0, 0, 0, 0, 0);
    // R3 R5 drain: queue 0 first, then queue 3 starts; new queue 1 packet waits
    for (int i = 0; i < 4; i++) step(0, 0, 0, 0, 1);
    for (int i = 0; i < 2; i++) step(1, 8'hC0 + 8'(i), i == 1, 1, 1);
    phase(60, 0, 100, 1, -1);
    // R8 packet not visible until its last byte is written
    for (int i = 0; i < 5; i++) step(1, 8'hD0 + 8'(i), i == 4, 2, 1);
    phase(20, 0, 100, 1, -1);
    phase(3000, 40, 95, 6, -1);
    phase(4000, 90, 30, 8, -1);
    phase(3000, 70, 60, 12, -1);
    phase(2000, 100, 100, 3, -1);
    while (rem != 0) phase(1, 100, 100, 1, -1);
    phase(400, 0, 100, 1, -1);
    chk(out_valid == 0, "R2 drained", out_valid, 0);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #1_500_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not complete");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule